// File: doc/BRIEF.md
# Segment-transfer DRAM core with channel buffers

This block is a synthesizable behavioural model of a two-bank DRAM core that is reached only through a set of channel buffers. Each row of a bank is cut into equal segments. Background commands move one whole segment at a time between the array and a buffer. A prefetch copies a segment of the bank's open row into a chosen channel. A restore names a channel and a segment, and the activate that follows it supplies the row that receives the data. Foreground column reads and writes touch only the channel buffers and never the array.

The command port is already decoded: one command code per cycle, with bank, row, segment, channel, column, an auto-precharge flag and write data alongside. Read data comes back one cycle after the read command. An error output pulses for one cycle after any command that breaks the sequencing rules, and such a command has no effect on the array or the buffers. Any channel can exchange data with any bank. Row count, segment count, channel count, column count and data width are parameters. The defaults are four rows, four segments, sixteen channels and sixteen byte-wide columns.

Top module: `seg_channel_dram`

## Requirements
- R1: The command code on cmd_i is 0 idle, 1 activate, 2 prefetch, 3 restore, 4 precharge, 5 column read, 6 column write. Code 7 is reserved and behaves as idle: no data or bank state changes, no error, no read valid.
- R2: After reset every channel column and every array segment reads as zero, both banks are idle, and err_o and rvalid_o are low.
- R3: A column write stores wdata_i at column col_i of channel chan_i. A column read returns that byte on rdata_o with rvalid_o high in the cycle after the command. rvalid_o is low after any other command.
- R4: Channel contents persist across activates, precharges, background transfers to other channels and accesses to other channels or columns, until they are overwritten.
- R5: A prefetch to a bank with an open row copies segment seg_i of that row into channel chan_i, column for column. No other channel changes.
- R6: A prefetch to an idle bank raises err_o in the next cycle and leaves every channel unchanged.
- R7: A restore to an idle bank is held pending. If the next non-idle command is an activate of the same bank, the channel is written into segment seg of the activated row, no other segment changes, and the bank opens on that row.
- R8: If the next non-idle command after a restore is anything other than an activate of the restore's bank, err_o is raised in the next cycle and the restore is discarded. The array is unchanged by it, and the offending command is still carried out.
- R9: With auto_pre_i set, a prefetch closes its bank after the transfer. A restore with auto_pre_i set leaves the bank idle after its activate.
- R10: An activate to a bank that is already open raises err_o and keeps the open row. A restore to an open bank raises err_o and is not recorded.
- R11: A precharge closes its bank. A precharge to an idle bank raises no error.
- R12: The banks are independent: opening, transferring or closing one bank never changes the state or data of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code (see R1) |
| bank_i | input | BANK_W (1) | Bank for activate, prefetch, restore, precharge |
| row_i | input | ROW_W (2) | Row for activate |
| seg_i | input | SEG_W (2) | Segment for prefetch and restore |
| chan_i | input | CH_W (4) | Channel for any transfer or column access |
| col_i | input | COL_W (4) | Column within the channel |
| auto_pre_i | input | 1 | Close the bank after a prefetch or restore |
| wdata_i | input | DW (8) | Column write data |
| rdata_o | output | DW (8) | Column read data |
| rvalid_o | output | 1 | rdata_o holds the result of the previous cycle's read |
| err_o | output | 1 | Previous command broke a sequencing rule |

## Verification
A marker byte is written to one channel. The bench then moves it out to a segment by restore and back into fresh channels by prefetch. Reading a neighbouring segment, column or bank returns zero, so each read shows whether the copy landed only at its intended place. The illegal orderings are each run once: a prefetch or restore against the wrong bank state, a second activate, and a restore interrupted by a read or by an activate of the other bank. For each one, a later read shows that the error flag came with no change to the data. Auto-precharge and plain precharge are told apart by whether a following prefetch is refused.

// File: rtl/scd_pkg.sv
package scd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PFC = 3'd2,
        CMD_RST = 3'd3,
        CMD_PRE = 3'd4,
        CMD_RD  = 3'd5,
        CMD_WR  = 3'd6
    } scd_cmd_e;

    localparam logic [2:0] CMD_RSVD = 3'd7;

endpackage

// File: rtl/scd_bank_state.sv
module scd_bank_state #(
    parameter int ROW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.open = 1'b1;
            st_d.row  = row_i;
        end else if (clr_i) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;
    assign row_o  = st_q.row;

    // R10: the controller never re-activates a bank that is already open
    a_r10_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.open |-> !set_i);

    // R10: the open row only moves through a new activate
    a_r10_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && !set_i) |=> $stable(st_q.row));

endmodule

// File: rtl/scd_seg_array.sv
module scd_seg_array #(
    parameter int NBANK    = 2,
    parameter int ROWS     = 4,
    parameter int NSEG     = 4,
    parameter int SEG_BITS = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NBANK)-1:0]    rd_bank_i,
    input  logic [$clog2(ROWS)-1:0]     rd_row_i,
    input  logic [$clog2(NSEG)-1:0]     rd_seg_i,
    output logic [SEG_BITS-1:0]         rd_data_o,
    input  logic                        wr_i,
    input  logic [$clog2(NBANK)-1:0]    wr_bank_i,
    input  logic [$clog2(ROWS)-1:0]     wr_row_i,
    input  logic [$clog2(NSEG)-1:0]     wr_seg_i,
    input  logic [SEG_BITS-1:0]         wr_data_i
);

    localparam int NENT  = NBANK * ROWS * NSEG;
    localparam int IDX_W = $clog2(NENT);

    typedef struct packed {
        logic [NENT-1:0][SEG_BITS-1:0] seg;
    } arr_t;

    arr_t st_d, st_q;
    logic [IDX_W-1:0] rd_idx, wr_idx;

    always_comb begin
        rd_idx = (IDX_W'(rd_bank_i) * IDX_W'(ROWS) + IDX_W'(rd_row_i)) * IDX_W'(NSEG)
                 + IDX_W'(rd_seg_i);
        wr_idx = (IDX_W'(wr_bank_i) * IDX_W'(ROWS) + IDX_W'(wr_row_i)) * IDX_W'(NSEG)
                 + IDX_W'(wr_seg_i);
        st_d = st_q;
        if (wr_i) st_d.seg[wr_idx] = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.seg[rd_idx];

    // R7: segments change only when a restore is committed
    a_r7_array_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(st_q));

endmodule

// File: rtl/scd_chan_file.sv
module scd_chan_file #(
    parameter int NCH  = 16,
    parameter int COLS = 16,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_i,
    input  logic                     wr_i,
    input  logic [$clog2(NCH)-1:0]   ch_i,
    input  logic [$clog2(COLS)-1:0]  col_i,
    input  logic [DW-1:0]            wdata_i,
    input  logic                     load_i,
    input  logic [COLS*DW-1:0]       load_data_i,
    input  logic [$clog2(NCH)-1:0]   peek_ch_i,
    output logic [COLS*DW-1:0]       peek_o,
    output logic [DW-1:0]            rdata_o,
    output logic                     rvalid_o
);

    localparam int SEG_BITS = COLS * DW;
    localparam int BW       = $clog2(SEG_BITS);

    typedef struct packed {
        logic [NCH-1:0][SEG_BITS-1:0] chan;
        logic [DW-1:0]                rdata;
        logic                         rvalid;
    } cf_t;

    cf_t st_d, st_q;
    logic [BW-1:0] base;

    always_comb begin
        base = BW'(col_i) * BW'(DW);
        st_d = st_q;
        st_d.rvalid = rd_i;
        if (rd_i)   st_d.rdata = st_q.chan[ch_i][base +: DW];
        if (wr_i)   st_d.chan[ch_i][base +: DW] = wdata_i;
        if (load_i) st_d.chan[ch_i] = load_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign peek_o   = st_q.chan[peek_ch_i];
    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;

    // R4: buffers hold their contents unless written or loaded
    a_r4_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !load_i) |=> $stable(st_q.chan));

endmodule

// File: rtl/seg_channel_dram.sv
module seg_channel_dram
    import scd_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int ROWS  = 4,
    parameter int NSEG  = 4,
    parameter int NCH   = 16,
    parameter int COLS  = 16,
    parameter int DW    = 8,
    localparam int BANK_W = $clog2(NBANK),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int SEG_W  = $clog2(NSEG),
    localparam int CH_W   = $clog2(NCH),
    localparam int COL_W  = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              auto_pre_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              rvalid_o,
    output logic              err_o
);

    localparam int SEG_BITS = COLS * DW;

    typedef struct packed {
        logic              pend_v;
        logic [BANK_W-1:0] pend_bank;
        logic [SEG_W-1:0]  pend_seg;
        logic [CH_W-1:0]   pend_ch;
        logic              pend_ap;
        logic              err;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NBANK-1:0]            open_w, set_w, clr_w;
    logic [NBANK-1:0][ROW_W-1:0] row_w;
    logic                        quiet, normal;
    logic                        pf_load, rs_write, col_rd, col_wr;
    logic [SEG_BITS-1:0]         seg_rd, chan_peek;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        set_w    = '0;
        clr_w    = '0;
        pf_load  = 1'b0;
        rs_write = 1'b0;
        col_rd   = 1'b0;
        col_wr   = 1'b0;
        normal   = 1'b1;
        quiet    = (cmd_i == CMD_NOP) || (cmd_i == CMD_RSVD);

        if (st_q.pend_v && !quiet) begin
            st_d.pend_v = 1'b0;
            if (cmd_i == CMD_ACT && bank_i == st_q.pend_bank) begin
                normal   = 1'b0;
                rs_write = 1'b1;
                if (!st_q.pend_ap) set_w[bank_i] = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end

        if (normal) begin
            case (cmd_i)
                CMD_ACT: begin
                    if (open_w[bank_i]) st_d.err = 1'b1;
                    else                set_w[bank_i] = 1'b1;
                end
                CMD_PFC: begin
                    if (!open_w[bank_i]) begin
                        st_d.err = 1'b1;
                    end else begin
                        pf_load = 1'b1;
                        if (auto_pre_i) clr_w[bank_i] = 1'b1;
                    end
                end
                CMD_RST: begin
                    if (open_w[bank_i]) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.pend_v    = 1'b1;
                        st_d.pend_bank = bank_i;
                        st_d.pend_seg  = seg_i;
                        st_d.pend_ch   = chan_i;
                        st_d.pend_ap   = auto_pre_i;
                    end
                end
                CMD_PRE: clr_w[bank_i] = 1'b1;
                CMD_RD:  col_rd = 1'b1;
                CMD_WR:  col_wr = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        scd_bank_state #(.ROW_W(ROW_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_w[b]),
            .clr_i  (clr_w[b]),
            .row_i  (row_i),
            .open_o (open_w[b]),
            .row_o  (row_w[b])
        );
    end

    scd_seg_array #(
        .NBANK(NBANK), .ROWS(ROWS), .NSEG(NSEG), .SEG_BITS(SEG_BITS)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_bank_i (bank_i),
        .rd_row_i  (row_w[bank_i]),
        .rd_seg_i  (seg_i),
        .rd_data_o (seg_rd),
        .wr_i      (rs_write),
        .wr_bank_i (st_q.pend_bank),
        .wr_row_i  (row_i),
        .wr_seg_i  (st_q.pend_seg),
        .wr_data_i (chan_peek)
    );

    scd_chan_file #(.NCH(NCH), .COLS(COLS), .DW(DW)) u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (col_rd),
        .wr_i        (col_wr),
        .ch_i        (chan_i),
        .col_i       (col_i),
        .wdata_i     (wdata_i),
        .load_i      (pf_load),
        .load_data_i (seg_rd),
        .peek_ch_i   (st_q.pend_ch),
        .peek_o      (chan_peek),
        .rdata_o     (rdata_o),
        .rvalid_o    (rvalid_o)
    );

    // R6: prefetch against an idle bank is refused
    a_r6_pfc_idle_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PFC && !st_q.pend_v && !open_w[bank_i]) |=> err_o);

    // R8: a restore not followed by its activate is flagged
    a_r8_break_err: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend_v && !quiet && !(cmd_i == CMD_ACT && bank_i == st_q.pend_bank))
        |=> err_o);

    // R3: read data is valid exactly one cycle after a column read
    a_r3_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RD) |=> rvalid_o);

    a_r3_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_RD) |=> !rvalid_o);

    // R11: precharge leaves its bank idle
    a_r11_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && !st_q.pend_v) |=> !open_w[$past(bank_i)]);

    // R1: the reserved code is silent
    a_r1_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_RSVD) |=> (!err_o && !rvalid_o));

endmodule

// File: tb/seg_channel_dram_bench.sv
`timescale 1ns/1ps
module seg_channel_dram_bench;

    typedef struct packed {
        logic [2:0] cmd;
        logic       bank;
        logic [1:0] row;
        logic [1:0] seg;
        logic [3:0] ch;
        logic [3:0] col;
        logic       ap;
        logic [7:0] wd;
        logic       chk;
        logic [7:0] exp_rd;
        logic       exp_err;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(input int c, input int b, input int r, input int s,
                                input int ch, input int col, input int ap, input int wd,
                                input int chk, input int ex, input int er, input int rq);
        vec_t v;
        v.cmd = 3'(c);     v.bank = 1'(b);   v.row = 2'(r);   v.seg = 2'(s);
        v.ch = 4'(ch);     v.col = 4'(col);  v.ap = 1'(ap);   v.wd = 8'(wd);
        v.chk = 1'(chk);   v.exp_rd = 8'(ex); v.exp_err = 1'(er); v.req = 4'(rq);
        return v;
    endfunction

    localparam int NV = 51;
    // codes: 0 idle 1 act 2 prefetch 3 restore 4 precharge 5 read 6 write 7 reserved
    localparam vec_t VEC [NV] = '{
        mk(6,0,0,0, 1, 3,0,8'hA5,0,8'h00,0, 3),  // R3 write marker
        mk(5,0,0,0, 1, 3,0,0,    1,8'hA5,0, 3),  // R3 read back
        mk(5,0,0,0, 1, 2,0,0,    1,8'h00,0, 4),  // R4 neighbour column
        mk(6,0,0,0, 2, 3,0,8'h5A,0,8'h00,0, 3),
        mk(5,0,0,0, 1, 3,0,0,    1,8'hA5,0, 4),  // R4 other channel write
        mk(2,0,0,0, 1, 0,0,0,    0,8'h00,1, 6),  // R6 prefetch idle bank
        mk(5,0,0,0, 1, 3,0,0,    1,8'hA5,0, 6),  // R6 channel unchanged
        mk(3,0,0,2, 1, 0,0,0,    0,8'h00,0, 7),  // R7 restore ch1 -> seg2
        mk(1,0,1,0, 0, 0,0,0,    0,8'h00,0, 7),  // R7 activate row1
        mk(2,0,0,2, 5, 0,0,0,    0,8'h00,0, 5),  // R5 prefetch seg2 -> ch5
        mk(5,0,0,0, 5, 3,0,0,    1,8'hA5,0, 7),
        mk(2,0,0,1, 6, 0,0,0,    0,8'h00,0, 5),
        mk(5,0,0,0, 6, 3,0,0,    1,8'h00,0, 7),  // R7 other segment untouched
        mk(1,0,2,0, 0, 0,0,0,    0,8'h00,1,10),  // R10 act on open bank
        mk(2,0,0,2, 7, 0,0,0,    0,8'h00,0,10),
        mk(5,0,0,0, 7, 3,0,0,    1,8'hA5,0,10),  // R10 row1 kept
        mk(3,0,0,0, 2, 0,0,0,    0,8'h00,1,10),  // R10 restore on open bank
        mk(4,0,0,0, 0, 0,0,0,    0,8'h00,0,11),  // R11 precharge
        mk(4,0,0,0, 0, 0,0,0,    0,8'h00,0,11),  // R11 precharge idle
        mk(2,0,0,2, 7, 0,0,0,    0,8'h00,1,11),  // R11 bank closed
        mk(1,1,1,0, 0, 0,0,0,    0,8'h00,0,12),  // R12 bank1 row1
        mk(2,1,0,2, 8, 0,0,0,    0,8'h00,0,12),
        mk(5,0,0,0, 8, 3,0,0,    1,8'h00,0,12),  // R12 bank1 not written
        mk(2,1,0,2, 9, 0,1,0,    0,8'h00,0, 9),  // R9 prefetch with auto close
        mk(2,1,0,0, 9, 0,0,0,    0,8'h00,1, 9),
        mk(3,0,0,3, 2, 0,1,0,    0,8'h00,0, 9),  // R9 restore with auto close
        mk(1,0,3,0, 0, 0,0,0,    0,8'h00,0, 9),
        mk(2,0,0,3,10, 0,0,0,    0,8'h00,1, 9),
        mk(1,0,3,0, 0, 0,0,0,    0,8'h00,0, 7),
        mk(2,0,0,3,10, 0,1,0,    0,8'h00,0, 7),
        mk(5,0,0,0,10, 3,0,0,    1,8'h5A,0, 7),  // R7 row3 seg3 holds ch2
        mk(3,0,0,0, 1, 0,0,0,    0,8'h00,0, 8),  // R8 restore pending
        mk(0,0,0,0, 0, 0,0,0,    0,8'h00,0, 8),  // idle keeps it pending
        mk(5,0,0,0, 1, 3,0,0,    1,8'hA5,1, 8),  // R8 read breaks it, still reads
        mk(1,0,0,0, 0, 0,0,0,    0,8'h00,0, 8),
        mk(2,0,0,0,11, 0,0,0,    0,8'h00,0, 8),
        mk(5,0,0,0,11, 3,0,0,    1,8'h00,0, 8),  // R8 restore discarded
        mk(7,0,0,0, 1, 3,0,8'hFF,0,8'h00,0, 1),  // R1 reserved code
        mk(5,0,0,0, 1, 3,0,0,    1,8'hA5,0, 1),
        mk(4,0,0,0, 0, 0,0,0,    0,8'h00,0,11),
        mk(3,1,0,1, 1, 0,0,0,    0,8'h00,0, 8),
        mk(1,0,2,0, 0, 0,0,0,    0,8'h00,1, 8),  // R8 act of other bank
        mk(2,0,0,0,12, 0,0,0,    0,8'h00,0, 8),  // R8 that act still opened bank0
        mk(1,1,1,0, 0, 0,0,0,    0,8'h00,0, 8),
        mk(2,1,0,1,13, 0,0,0,    0,8'h00,0, 8),
        mk(5,0,0,0,13, 3,0,0,    1,8'h00,0, 8),
        mk(6,0,0,0,15,15,0,8'h3C,0,8'h00,0, 3),  // R3 last channel, last column
        mk(5,0,0,0,15,15,0,0,    1,8'h3C,0, 3),
        mk(5,0,0,0, 5, 3,0,0,    1,8'hA5,0, 4),  // R4 persistence
        mk(5,0,0,0,14, 0,0,0,    1,8'h00,0, 2),  // R2 untouched channel zero
        mk(5,0,0,0, 5, 2,0,0,    1,8'h00,0, 5)   // R5 column positions kept
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = '0;
    logic       bank_i = 1'b0;
    logic [1:0] row_i = '0;
    logic [1:0] seg_i = '0;
    logic [3:0] chan_i = '0;
    logic [3:0] col_i = '0;
    logic       auto_pre_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       rvalid_o;
    logic       err_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_channel_dram u_seg_channel_dram (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .row_i(row_i),
        .seg_i(seg_i), .chan_i(chan_i), .col_i(col_i), .auto_pre_i(auto_pre_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input int rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        cmd_i = v.cmd; bank_i = v.bank; row_i = v.row; seg_i = v.seg;
        chan_i = v.ch; col_i = v.col; auto_pre_i = v.ap; wdata_i = v.wd;
        @(negedge clk);
        check(err_o == v.exp_err, int'(v.req), "err", int'(err_o), int'(v.exp_err));
        check(rvalid_o == v.chk, int'(v.req), "rvalid", int'(rvalid_o), int'(v.chk));
        if (v.chk)
            check(rdata_o == v.exp_rd, int'(v.req), "rdata", int'(rdata_o), int'(v.exp_rd));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check(err_o == 1'b0, 2, "err after reset", int'(err_o), 0);
        check(rvalid_o == 1'b0, 2, "rvalid after reset", int'(rvalid_o), 0);
        apply(mk(5,0,0,0, 0, 0,0,0,1,8'h00,0, 2));
        apply(mk(5,0,0,0,15,15,0,0,1,8'h00,0, 2));
        apply(mk(2,1,0,0, 3, 0,0,0,0,8'h00,1, 2));  // R2 bank1 idle

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R2 reset in the middle of activity
        rst_n = 1'b0;
        cmd_i = 3'd0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(err_o == 1'b0, 2, "err after second reset", int'(err_o), 0);
        apply(mk(5,0,0,0, 1, 3,0,0,1,8'h00,0, 2));  // R2 channel cleared
        apply(mk(2,1,0,1, 4, 0,0,0,0,8'h00,1, 2));  // R2 bank1 closed again
        apply(mk(1,0,1,0, 0, 0,0,0,0,8'h00,0, 2));
        apply(mk(2,0,0,2, 4, 0,0,0,0,8'h00,0, 2));
        apply(mk(5,0,0,0, 4, 3,0,0,1,8'h00,0, 2));  // R2 array cleared

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule